// File: doc/BRIEF.md
# Configurable GPIO Port with Per-Pin Interrupts

This block is an eight-pin general-purpose I/O port that sits behind a small register bus. Each pin is set up on its own. Its behaviour comes from a four-bit code. The code is built from the same-numbered bit of four registers: stored data, direction, first alternate and second alternate. The decoded code makes the pin a push-pull output, a plain input, an open-drain or open-source driver, a level-sensitive interrupt input or an edge-sensitive interrupt input. The block drives an output-enable and an output value for each pad. It resynchronises the pad inputs and raises one interrupt request line per pin.

A read of the data address always returns the synchronised level seen on the pins. The stored data bit is held internally and only feeds the drive value and the mode decode. Edge interrupts stay latched until software writes a one to the matching bit of a write-only clear address. Level interrupts follow the pin and are not latched. The synchronised pin levels are also brought out unchanged, so an alternate peripheral can use them as its input.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset the stored data, first-alternate and second-alternate registers are all zero and the direction register is all ones. Every pin is then an input with pin_oe low, and every irq line is low.
- R2: A read of address 0 returns the pin levels delayed by two clock edges through the synchroniser, in every mode, and never the stored data value.
- R3: The code {alt2,alt1,dir,data} = 000d drives the pin push-pull: pin_oe is 1 and pin_out equals d.
- R4: Code 010d makes the pin open-drain. With d=0 the pin drives low (pin_oe=1, pin_out=0). With d=1 the pin is released (pin_oe=0).
- R5: Code 011d makes the pin open-source. With d=1 the pin drives high (pin_oe=1, pin_out=1). With d=0 the pin is released (pin_oe=0).
- R6: Codes 001x and every code with alt2=1 leave pin_oe at 0. Whenever pin_oe is 0, pin_out is 0.
- R7: Code 10xd is a level interrupt. irq is 1 exactly while the synchronised pin level equals d. It is not latched.
- R8: Code 11xd is an edge interrupt. A rising edge of the synchronised level (d=1) or a falling edge (d=0) sets the pin's irq. The irq then stays set until it is cleared, and an edge of the other direction does not set it.
- R9: Writing to address 4 clears the latched edge interrupt of each pin whose write bit is 1. Bits written as 0 have no effect. If a new edge arrives in the same cycle as the clear, the interrupt stays set.
- R10: A pin not in an interrupt mode (alt2=0) holds irq at 0. Leaving edge mode drops its latched interrupt.
- R11: Addresses 1, 2 and 3 read back the direction, first-alternate and second-alternate registers. Address 4 reads as zero. Each pin's mode depends only on its own bit of each register.
- R12: alt_rx carries the synchronised pin levels, with the same timing as the address-0 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 data, 1 direction, 2 alt1, 3 alt2, 4 clear) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output values |
| alt_rx | output | 8 | Synchronised pin levels for an alternate peripheral |
| irq | output | 8 | Per-pin interrupt requests |

## Verification
The hardest case to reach from the ports is a fresh pin edge that reaches the edge detector in the same cycle as a clear write for that pin. The stimulus sets the latch, lets an edge of the ignored direction pass, and then flips the pin. It counts two clock edges for the synchroniser and puts the clear write on the third edge, so both events meet. Random register writes and pin patterns from a fixed seed go through all sixteen codes on every pin. A bench model checks the drive values, the read-back data and the level interrupts against these.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the GPIO port: register addresses and the decoded
// per-pin function. Assumes a 3-bit register address.
package gpio_port_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_DATA = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_DIR  = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_ALT1 = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_ALT2 = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_CLR  = 3'd4;

    typedef enum logic [3:0] {
        PM_DRIVE_LO,
        PM_DRIVE_HI,
        PM_INPUT,
        PM_ODRAIN_LO,
        PM_ODRAIN_OFF,
        PM_OSRC_OFF,
        PM_OSRC_HI,
        PM_LEVEL_LO,
        PM_LEVEL_HI,
        PM_EDGE_FALL,
        PM_EDGE_RISE
    } pin_mode_t;

    // Map a {alt2, alt1, dir, data} code onto a pin function.
    function automatic pin_mode_t classify(input logic [3:0] code);
        pin_mode_t m;
        casez (code)
            4'b0000: m = PM_DRIVE_LO;
            4'b0001: m = PM_DRIVE_HI;
            4'b001?: m = PM_INPUT;
            4'b0100: m = PM_ODRAIN_LO;
            4'b0101: m = PM_ODRAIN_OFF;
            4'b0110: m = PM_OSRC_OFF;
            4'b0111: m = PM_OSRC_HI;
            4'b10?0: m = PM_LEVEL_LO;
            4'b10?1: m = PM_LEVEL_HI;
            4'b11?0: m = PM_EDGE_FALL;
            default: m = PM_EDGE_RISE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for the asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is needed across pins.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw pad level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // shift towards the settled output
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_mode_decode.sv
`timescale 1ns/1ps
// Per-pin decode of the four control bits into pad drive and interrupt kind.
// Purely combinational; assumes the control registers are stable between writes.
module gpio_mode_decode
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] alt1_q,
    input  logic [WIDTH-1:0] alt2_q,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] lvl_en,
    output logic [WIDTH-1:0] edge_en,
    output logic [WIDTH-1:0] act_hi
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            pin_mode_t mode;

            // classify this pin's code and derive its drive and interrupt kind
            always_comb begin
                mode       = classify({alt2_q[i], alt1_q[i], dir_q[i], data_q[i]});
                pin_oe[i]  = 1'b0;
                pin_out[i] = 1'b0;
                lvl_en[i]  = 1'b0;
                edge_en[i] = 1'b0;
                act_hi[i]  = data_q[i];
                case (mode)
                    PM_DRIVE_LO:  pin_oe[i] = 1'b1;
                    PM_DRIVE_HI:  begin pin_oe[i] = 1'b1; pin_out[i] = 1'b1; end
                    PM_ODRAIN_LO: pin_oe[i] = 1'b1;
                    PM_OSRC_HI:   begin pin_oe[i] = 1'b1; pin_out[i] = 1'b1; end
                    PM_LEVEL_LO,
                    PM_LEVEL_HI:  lvl_en[i] = 1'b1;
                    PM_EDGE_FALL,
                    PM_EDGE_RISE: edge_en[i] = 1'b1;
                    default:      ;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_irq.sv
`timescale 1ns/1ps
// Per-pin interrupt detection: level interrupts follow the synchronised pin,
// edge interrupts latch until a write-one clear. A same-cycle edge beats a clear.
// Assumes sync_in is already synchronous to clk.
module gpio_irq #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    input  logic [WIDTH-1:0] lvl_en,
    input  logic [WIDTH-1:0] edge_en,
    input  logic [WIDTH-1:0] act_hi,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] irq
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] edge_hit;

    // keep a one-cycle-delayed copy for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            // select the edge direction this pin listens for
            always_comb begin
                edge_hit[i] = act_hi[i] ? (sync_in[i] & ~prev_q[i])
                                        : (~sync_in[i] & prev_q[i]);
            end

            // hold the edge latch; a new edge wins over a clear
            always_ff @(posedge clk) begin
                if (!rst_n)            latch_q[i] <= 1'b0;
                else if (!edge_en[i])  latch_q[i] <= 1'b0;
                else if (edge_hit[i])  latch_q[i] <= 1'b1;
                else if (clr_bits[i])  latch_q[i] <= 1'b0;
            end

            // combine level and edge sources into the request line
            always_comb begin
                irq[i] = (lvl_en[i] & (sync_in[i] == act_hi[i])) |
                         (edge_en[i] & latch_q[i]);
            end

            assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                edge_en[i] && latch_q[i] && !clr_bits[i] |=> latch_q[i]);

            assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
                edge_en[i] && clr_bits[i] && !edge_hit[i] |=> !latch_q[i]);

            assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
                edge_en[i] && edge_hit[i] |=> latch_q[i]);

            assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !lvl_en[i] && !edge_en[i] |-> !irq[i]);
        end
    endgenerate

endmodule

// File: rtl/gpio_port_irq.sv
`timescale 1ns/1ps
// Eight-pin GPIO port top: control registers, read mux, synchroniser, mode
// decode and interrupt detection. Reads are combinational on reg_addr; writes
// take effect at the next clock edge. Assumes pin_in is asynchronous.
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  alt_rx,
    output logic [WIDTH-1:0]  irq
);

    localparam logic [WIDTH-1:0] DIR_RESET = '1;

    logic [WIDTH-1:0] data_q, dir_q, alt1_q, alt2_q;
    logic [WIDTH-1:0] sync_lvl;
    logic [WIDTH-1:0] lvl_en, edge_en, act_hi;
    logic [WIDTH-1:0] clr_bits;
    logic [1:0]       since_rst;

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= DIR_RESET;
            alt1_q <= '0;
            alt2_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_DATA: data_q <= reg_wdata;
                ADDR_DIR:  dir_q  <= reg_wdata;
                ADDR_ALT1: alt1_q <= reg_wdata;
                ADDR_ALT2: alt2_q <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // write-one-to-clear strobe, live only during the write cycle
    always_comb begin
        clr_bits = (reg_we && reg_addr == ADDR_CLR) ? reg_wdata : '0;
    end

    // read mux: data address returns the pin level, not the stored bit
    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = sync_lvl;
            ADDR_DIR:  reg_rdata = dir_q;
            ADDR_ALT1: reg_rdata = alt1_q;
            ADDR_ALT2: reg_rdata = alt2_q;
            default:   reg_rdata = '0;
        endcase
    end

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    gpio_mode_decode #(.WIDTH(WIDTH)) u_decode (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .alt1_q  (alt1_q),
        .alt2_q  (alt2_q),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .lvl_en  (lvl_en),
        .edge_en (edge_en),
        .act_hi  (act_hi)
    );

    gpio_irq #(.WIDTH(WIDTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_lvl),
        .lvl_en   (lvl_en),
        .edge_en  (edge_en),
        .act_hi   (act_hi),
        .clr_bits (clr_bits),
        .irq      (irq)
    );

    assign alt_rx = sync_lvl;

    // saturating count of edges since reset, for assertion windows
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == DIR_RESET && data_q == '0 &&
                          alt1_q == '0 && alt2_q == '0 && pin_oe == '0));

    assert_read_tracks_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && reg_addr == ADDR_DATA) |-> reg_rdata == $past(pin_in, 2));

    assert_undriven_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

endmodule

// File: tb/gpio_port_irq_test.sv
`timescale 1ns/1ps
module gpio_port_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 8'd0;
    logic [7:0] pin_oe, pin_out, alt_rx, irq;

    int total = 0;
    int bad = 0;

    logic [7:0] m_dat, m_dir, m_a1, m_a2;

    gpio_port_irq uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .alt_rx(alt_rx), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] code_of(input int i);
        return {m_a2[i], m_a1[i], m_dir[i], m_dat[i]};
    endfunction

    function automatic logic exp_oe(input logic [3:0] c);
        return (c == 4'b0000) || (c == 4'b0001) || (c == 4'b0100) || (c == 4'b0111);
    endfunction

    function automatic logic exp_out(input logic [3:0] c);
        return (c == 4'b0001) || (c == 4'b0111);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd0;
        case (a)
            3'd0: m_dat = d;
            3'd1: m_dir = d;
            3'd2: m_a1 = d;
            3'd3: m_a2 = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    // Configure a single pin's code, leaving the other pins unchanged.
    task automatic set_pin(input int i, input logic [3:0] c);
        logic [7:0] v;
        v = m_a2; v[i] = c[3]; wr(3'd3, v);
        v = m_a1; v[i] = c[2]; wr(3'd2, v);
        v = m_dir; v[i] = c[1]; wr(3'd1, v);
        v = m_dat; v[i] = c[0]; wr(3'd0, v);
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] exp_irq, irq_mask, e_oe, e_out;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_dat = 8'h00; m_dir = 8'hFF; m_a1 = 8'h00; m_a2 = 8'h00;

        pin_in = 8'hA5;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", pin_oe, 8'h00);
        check("R1 irq after reset", irq, 8'h00);
        rd(3'd1, r); check("R1 dir reset", r, 8'hFF);
        rd(3'd2, r); check("R1 alt1 reset", r, 8'h00);
        rd(3'd3, r); check("R1 alt2 reset", r, 8'h00);
        idle(2);
        rd(3'd0, r); check("R2 read pin level", r, 8'hA5);
        check("R12 alt_rx level", alt_rx, 8'hA5);

        // R2 latency: change pins, observe the new value after two edges
        @(negedge clk); pin_in = 8'h3C;
        @(negedge clk); rd(3'd0, r); check("R2 one edge old value", r, 8'hA5);
        @(negedge clk); rd(3'd0, r); check("R2 two edges new value", r, 8'h3C);
        check("R12 alt_rx timing", alt_rx, 8'h3C);

        // R3 push-pull, data read still returns the pin, not the stored bits
        wr(3'd0, 8'hF0); wr(3'd1, 8'h00);
        idle(1);
        check("R3 oe push-pull", pin_oe, 8'hFF);
        check("R3 out push-pull", pin_out, 8'hF0);
        rd(3'd0, r); check("R2 read ignores stored data", r, 8'h3C);

        // R4 open-drain and R5 open-source
        wr(3'd2, 8'hFF); wr(3'd0, 8'h0F);
        idle(1);
        check("R4 open-drain oe", pin_oe, 8'hF0);
        check("R4 open-drain out", pin_out, 8'h00);
        wr(3'd1, 8'hFF);
        idle(1);
        check("R5 open-source oe", pin_oe, 8'h0F);
        check("R5 open-source out", pin_out, 8'h0F);
        rd(3'd4, r); check("R11 clear reads zero", r, 8'h00);

        // random sweep through all codes
        for (int it = 0; it < 400; it++) begin
            wr(3'($urandom_range(0, 3)), 8'($urandom));
            pin_in = 8'($urandom);
            idle(3);
            e_oe = '0; e_out = '0; exp_irq = '0; irq_mask = '0;
            for (int i = 0; i < 8; i++) begin
                logic [3:0] c;
                c = code_of(i);
                e_oe[i] = exp_oe(c);
                e_out[i] = exp_out(c);
                if (c[3:2] == 2'b10) exp_irq[i] = (pin_in[i] == c[0]);
                if (c[3:2] != 2'b11) irq_mask[i] = 1'b1;
            end
            check("R3 R4 R5 R6 random oe", pin_oe, e_oe);
            check("R3 R4 R5 random out", pin_out, e_out);
            check("R7 R10 random irq", irq & irq_mask, exp_irq);
            rd(3'd0, r); check("R2 random read", r, pin_in);
            rd(3'd1, r); check("R11 dir readback", r, m_dir);
            rd(3'd2, r); check("R11 alt1 readback", r, m_a1);
            rd(3'd3, r); check("R11 alt2 readback", r, m_a2);
        end

        // back to all inputs
        wr(3'd3, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'hFF); wr(3'd0, 8'h00);
        pin_in = 8'h00;
        idle(4);
        check("R6 all inputs", pin_oe, 8'h00);
        check("R10 no irq as inputs", irq, 8'h00);

        // R7 level active low on pin 5
        set_pin(5, 4'b1000);
        idle(3);
        check("R7 level low asserted", irq[5], 1'b1);
        @(negedge clk); pin_in[5] = 1'b1;
        idle(3);
        check("R7 level not latched", irq[5], 1'b0);
        set_pin(5, 4'b1011);
        idle(1);
        check("R7 level high asserted", irq[5], 1'b1);
        set_pin(5, 4'b0010);
        idle(1);
        check("R10 input mode quiet", irq[5], 1'b0);

        // R8 rising edge on pin 0
        set_pin(0, 4'b1101);
        idle(3);
        check("R8 no edge yet", irq[0], 1'b0);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(4);
        check("R8 rising latched", irq[0], 1'b1);
        check("R11 other pins untouched", irq & 8'hDE, 8'h00);
        @(negedge clk); pin_in[0] = 1'b0;
        idle(4);
        check("R8 held through falling", irq[0], 1'b1);
        wr(3'd4, 8'hFE);
        idle(1);
        check("R9 zero bit no effect", irq[0], 1'b1);
        wr(3'd4, 8'h01);
        idle(1);
        check("R9 clear by one", irq[0], 1'b0);

        // R9 same-cycle edge and clear: the edge wins
        @(negedge clk); pin_in[0] = 1'b1;
        idle(4);
        check("R8 relatched", irq[0], 1'b1);
        @(negedge clk); pin_in[0] = 1'b0;
        idle(4);
        @(negedge clk); pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
        @(negedge clk); reg_we = 1'b0; reg_addr = 3'd0;
        check("R9 edge beats clear", irq[0], 1'b1);
        wr(3'd4, 8'h01);
        idle(1);
        check("R9 later clear works", irq[0], 1'b0);

        // R8 falling edge on pin 3, then R10 leaving edge mode drops latch
        pin_in[3] = 1'b1;
        set_pin(3, 4'b1100);
        idle(4);
        check("R8 falling idle", irq[3], 1'b0);
        @(negedge clk); pin_in[3] = 1'b0;
        idle(4);
        check("R8 falling latched", irq[3], 1'b1);
        set_pin(3, 4'b0010);
        set_pin(3, 4'b1100);
        idle(1);
        check("R10 latch dropped on mode exit", irq[3], 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule